// File: doc/BRIEF.md
# Iterative Support Accumulator with Index-List Formatter

This block collects the channel supports found by an iterative search over twelve channels. Each iteration reports a 12-bit bitmap with one bit per channel. The block ORs every bitmap it accepts into a cumulative register, so a channel that was active in any iteration stays marked. A start pulse empties the register before a new search begins.

When a beat carries the last-iteration flag, that beat is merged and the block freezes the cumulative bitmap. It then walks the bitmap one channel per cycle, lowest channel first, and builds two results. The first is a 4-bit support length. The second is a packed list of up to seven 4-bit channel indices. The result is presented to a downstream consumer with a valid flag that stays high until the consumer acknowledges it. If more than seven channels are set, the list keeps the lowest seven, the length stops at seven, and an overflow flag is raised.

Top module: `support_gather`

## Requirements
- R1: After reset, out_valid_o, out_len_o and out_ovf_o are all 0, and the cumulative bitmap is empty.
- R2: While collecting, each cycle with sup_valid_i high ORs sup_bits_i into the cumulative bitmap. A cycle with sup_valid_i low leaves the bitmap unchanged.
- R3: A beat with sup_valid_i and sup_last_i both high is merged, and it starts the conversion. out_valid_o rises exactly 12 clock edges after the edge that captured that beat.
- R4: out_len_o is the number of set bits in the frozen bitmap, saturated at 7.
- R5: out_idx_o holds slot k in bits [4k+3:4k] for k = 0..6. Filled slots carry channel numbers (0..11) in ascending order starting at slot 0. Every unused slot holds 4'hF.
- R6: When more than 7 bits are set, out_ovf_o is 1 and only the 7 lowest channel numbers are listed. Otherwise out_ovf_o is 0.
- R7: While out_valid_o is high and out_ack_i is low, out_valid_o, out_len_o, out_idx_o and out_ovf_o hold steady. An edge with out_ack_i high drops out_valid_o on that edge, and collection resumes.
- R8: Support beats that arrive during conversion or while the result is presented are not merged.
- R9: start_i clears the cumulative bitmap to zero and takes priority over a beat in the same cycle. In conversion or presentation, it also aborts the operation, and out_valid_o is low after that edge.
- R10: Without a start pulse, the cumulative bitmap carries over from one emitted result into the next sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Clears the cumulative bitmap and aborts any conversion or output |
| sup_valid_i | input | 1 | Qualifies sup_bits_i and sup_last_i |
| sup_bits_i | input | 12 | Per-iteration support bitmap, bit n = channel n |
| sup_last_i | input | 1 | Marks the final iteration of the sequence |
| out_ack_i | input | 1 | Consumer accepts the presented result |
| out_valid_o | output | 1 | Result is presented |
| out_len_o | output | 4 | Support length, saturated at 7 |
| out_idx_o | output | 28 | Seven 4-bit channel slots, slot k at bits [4k+3:4k] |
| out_ovf_o | output | 1 | More than seven channels were set |

## Verification
The tests cover four kinds of bitmap, each aimed at a different fault:
- Sparse bitmaps spread over several beats show whether the OR merge and the ascending slot order are right.
- An empty bitmap checks that all seven slots are filled with 4'hF.
- A full bitmap and random dense bitmaps with eight or more bits set check that the length saturates, that the overflow flag is set, and that the list is cut to the lowest seven channels.
- Beats with the valid flag low, or arriving during conversion or while the result is presented, are placed where a faulty merge would show up in the following result. A start pulse during conversion checks that the operation is aborted and the bitmap is cleared.

// File: rtl/supgat_pkg.sv
package supgat_pkg;

    typedef enum logic [1:0] {
        ST_COLLECT = 2'd0,
        ST_CONVERT = 2'd1,
        ST_PRESENT = 2'd2
    } gat_state_e;

endpackage

// File: rtl/supgat_merge.sv
module supgat_merge #(
    parameter int NCH = 12
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           clr_i,
    input  logic           en_i,
    input  logic [NCH-1:0] bits_i,
    output logic [NCH-1:0] acc_o
);

    typedef struct packed {
        logic [NCH-1:0] acc;
    } merge_st_t;

    merge_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.acc = '0;
        end else if (en_i) begin
            st_d.acc = st_q.acc | bits_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_o = st_q.acc;

    // R2 / R10: without a clear, bits already set are never lost
    a_r2_monotone: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clr_i |=> ((acc_o & $past(acc_o)) == $past(acc_o)));

    // R9: a clear empties the register on the next edge
    a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (acc_o == '0));

endmodule

// File: rtl/supgat_scan.sv
module supgat_scan #(
    parameter int NCH   = 12,
    parameter int MAXL  = 7,
    parameter int IDX_W = 4,
    parameter int LEN_W = 4
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  clr_i,
    input  logic                  load_i,
    input  logic [NCH-1:0]        map_i,
    output logic                  done_o,
    output logic [LEN_W-1:0]      len_o,
    output logic [MAXL*IDX_W-1:0] list_o,
    output logic                  ovf_o
);

    localparam int LIST_W = MAXL * IDX_W;
    localparam logic [IDX_W-1:0] FILL = {IDX_W{1'b1}};
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NCH - 1);
    localparam logic [LEN_W-1:0] LIMIT = LEN_W'(MAXL);

    typedef struct packed {
        logic              busy;
        logic [IDX_W-1:0]  cnt;
        logic [LEN_W-1:0]  len;
        logic              ovf;
        logic [NCH-1:0]    map;
        logic [LIST_W-1:0] list;
    } scan_st_t;

    scan_st_t st_d, st_q;
    logic     bit_hit;

    assign bit_hit = st_q.map[st_q.cnt];

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.busy = 1'b0;
        end else if (load_i) begin
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
            st_d.len  = '0;
            st_d.ovf  = 1'b0;
            st_d.map  = map_i;
            st_d.list = {MAXL{FILL}};
        end else if (st_q.busy) begin
            if (bit_hit) begin
                if (st_q.len < LIMIT) begin
                    st_d.list[int'(st_q.len) * IDX_W +: IDX_W] = st_q.cnt;
                    st_d.len = st_q.len + LEN_W'(1);
                end else begin
                    st_d.ovf = 1'b1;
                end
            end
            if (st_q.cnt == LAST) begin
                st_d.busy = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt + IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o = st_q.busy && (st_q.cnt == LAST);
    assign len_o  = st_q.len;
    assign list_o = st_q.list;
    assign ovf_o  = st_q.ovf;

    // R4: the listed length never passes the slot count
    a_r4_len_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.len <= LIMIT);

    // R6: overflow only once every slot is taken
    a_r6_ovf_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.ovf |-> (st_q.len == LIMIT));

    // R3: the walk counter only advances while busy
    a_r3_cnt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.busy && !clr_i && !load_i && st_q.cnt != LAST)
            |=> (st_q.cnt == $past(st_q.cnt) + IDX_W'(1)));

endmodule

// File: rtl/support_gather.sv
module support_gather
    import supgat_pkg::*;
#(
    parameter int NCH   = 12,
    parameter int MAXL  = 7,
    parameter int IDX_W = $clog2(NCH),
    parameter int LEN_W = 4
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  start_i,
    input  logic                  sup_valid_i,
    input  logic [NCH-1:0]        sup_bits_i,
    input  logic                  sup_last_i,
    input  logic                  out_ack_i,
    output logic                  out_valid_o,
    output logic [LEN_W-1:0]      out_len_o,
    output logic [MAXL*IDX_W-1:0] out_idx_o,
    output logic                  out_ovf_o
);

    typedef struct packed {
        gat_state_e state;
        logic       vld;
    } ctl_st_t;

    ctl_st_t        st_d, st_q;
    logic           accept;
    logic           load;
    logic           scan_done;
    logic [NCH-1:0] acc;
    logic [NCH-1:0] frozen;

    assign accept = sup_valid_i && !start_i && (st_q.state == ST_COLLECT);
    assign load   = accept && sup_last_i;
    assign frozen = acc | sup_bits_i;

    supgat_merge #(
        .NCH (NCH)
    ) u_merge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (start_i),
        .en_i   (accept),
        .bits_i (sup_bits_i),
        .acc_o  (acc)
    );

    supgat_scan #(
        .NCH   (NCH),
        .MAXL  (MAXL),
        .IDX_W (IDX_W),
        .LEN_W (LEN_W)
    ) u_scan (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (start_i),
        .load_i (load),
        .map_i  (frozen),
        .done_o (scan_done),
        .len_o  (out_len_o),
        .list_o (out_idx_o),
        .ovf_o  (out_ovf_o)
    );

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.state = ST_COLLECT;
            st_d.vld   = 1'b0;
        end else begin
            unique case (st_q.state)
                ST_COLLECT: begin
                    if (load) begin
                        st_d.state = ST_CONVERT;
                    end
                end
                ST_CONVERT: begin
                    if (scan_done) begin
                        st_d.state = ST_PRESENT;
                        st_d.vld   = 1'b1;
                    end
                end
                ST_PRESENT: begin
                    if (out_ack_i) begin
                        st_d.state = ST_COLLECT;
                        st_d.vld   = 1'b0;
                    end
                end
                default: begin
                    st_d.state = ST_COLLECT;
                    st_d.vld   = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{state: ST_COLLECT, vld: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid_o = st_q.vld;

    // R7: the presented result stays put until acknowledged
    a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_valid_o && !out_ack_i && !start_i) |=>
            (out_valid_o && $stable(out_len_o) && $stable(out_idx_o) && $stable(out_ovf_o)));

    // R7: an acknowledge ends the presentation
    a_r7_ack_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_valid_o && out_ack_i) |=> !out_valid_o);

    // R9: start aborts any output
    a_r9_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> !out_valid_o);

    // R3: a result only appears out of the conversion walk
    a_r3_rise_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(out_valid_o) |-> ($past(st_q.state) == ST_CONVERT));

endmodule

// File: tb/support_gather_test.sv
module support_gather_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        s_valid = 1'b0;
    logic [11:0] s_bits = '0;
    logic        s_last = 1'b0;
    logic        ack = 1'b0;
    logic        o_valid;
    logic [3:0]  o_len;
    logic [27:0] o_idx;
    logic        o_ovf;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [11:0] model_acc = '0;

    always #4 clk = ~clk;

    support_gather uut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .start_i     (start),
        .sup_valid_i (s_valid),
        .sup_bits_i  (s_bits),
        .sup_last_i  (s_last),
        .out_ack_i   (ack),
        .out_valid_o (o_valid),
        .out_len_o   (o_len),
        .out_idx_o   (o_idx),
        .out_ovf_o   (o_ovf)
    );

    function automatic int pop12(logic [11:0] m);
        int n = 0;
        for (int i = 0; i < 12; i++) n += int'(m[i]);
        return n;
    endfunction

    function automatic logic [3:0] exp_len(logic [11:0] m);
        int n = pop12(m);
        return (n > 7) ? 4'd7 : 4'(n);
    endfunction

    function automatic logic [27:0] exp_list(logic [11:0] m);
        logic [27:0] l = {7{4'hF}};
        int k = 0;
        for (int i = 0; i < 12; i++) begin
            if (m[i] && k < 7) begin
                l[k*4 +: 4] = 4'(i);
                k++;
            end
        end
        return l;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic beat(input logic v, input logic [11:0] b, input logic l);
        @(negedge clk);
        s_valid = v; s_bits = b; s_last = l;
        @(negedge clk);
        s_valid = 1'b0; s_last = 1'b0; s_bits = '0;
        if (v) model_acc = model_acc | b;
    endtask

    task automatic do_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        model_acc = '0;
    endtask

    task automatic wait_valid(input bit check_time, input string tag);
        int n = 0;
        while (n < 40) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (o_valid) break;
        end
        if (check_time) chk(n == 12, tag, n, 12);
        else chk(o_valid == 1'b1, tag, o_valid, 1);
    endtask

    task automatic check_result(input string tag);
        chk(o_len == exp_len(model_acc), {tag, " R4 len"}, o_len, exp_len(model_acc));
        chk(o_idx == exp_list(model_acc), {tag, " R5 list"}, o_idx, exp_list(model_acc));
        chk(o_ovf == (pop12(model_acc) > 7), {tag, " R6 ovf"}, o_ovf, pop12(model_acc) > 7);
    endtask

    task automatic do_ack();
        @(negedge clk);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        chk(o_valid == 1'b0, "R7 valid drops after ack", o_valid, 0);
    endtask

    initial begin
        int cyc = 0;
        while (!finished) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                errors++;
                $display("FAIL watchdog act=%0d exp=<150000", cyc);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [27:0] held_idx;
        logic [3:0]  held_len;
        void'($urandom(32'h5EED_0C11));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(o_valid == 1'b0, "R1 reset valid", o_valid, 0);
        chk(o_len == 4'd0, "R1 reset len", o_len, 0);
        chk(o_ovf == 1'b0, "R1 reset ovf", o_ovf, 0);

        // R2: sparse merge, valid-low beat ignored; R3 timing
        beat(1'b1, 12'h001, 1'b0);
        beat(1'b0, 12'h800, 1'b0);
        beat(1'b1, 12'h010, 1'b0);
        beat(1'b1, 12'h100, 1'b1);
        wait_valid(1'b1, "R3 latency");
        chk(model_acc == 12'h111, "R2 model", model_acc, 12'h111);
        check_result("R2 sparse");
        chk(o_idx == 28'hFFFF840, "R5 slot order", o_idx, 28'hFFFF840);

        // R7 hold, R8 beat during presentation
        held_idx = o_idx;
        held_len = o_len;
        @(negedge clk);
        s_valid = 1'b1; s_bits = 12'h002;
        repeat (3) @(negedge clk);
        s_valid = 1'b0; s_bits = '0;
        chk(o_valid && o_idx == held_idx && o_len == held_len, "R7 held", o_idx, held_idx);
        do_ack();

        // R10 carry-over, R8 beat during conversion
        beat(1'b1, 12'h000, 1'b1);
        @(negedge clk);
        s_valid = 1'b1; s_bits = 12'h400;
        @(negedge clk);
        s_valid = 1'b0; s_bits = '0;
        wait_valid(1'b0, "R10 valid");
        chk(o_idx == 28'hFFFF840, "R10 R8 carried map only", o_idx, 28'hFFFF840);
        do_ack();

        // R5 empty map
        do_start();
        beat(1'b1, 12'h000, 1'b1);
        wait_valid(1'b1, "R3 latency empty");
        chk(o_idx == 28'hFFFFFFF && o_len == 4'd0, "R5 empty fill", o_idx, 28'hFFFFFFF);
        do_ack();

        // R6 full map
        do_start();
        beat(1'b1, 12'hFFF, 1'b1);
        wait_valid(1'b1, "R3 latency full");
        chk(o_idx == 28'h6543210 && o_len == 4'd7 && o_ovf, "R6 full", o_idx, 28'h6543210);
        do_ack();

        // R9 start same cycle as beat, and abort mid-conversion
        do_start();
        beat(1'b1, 12'h0F0, 1'b1);
        repeat (4) @(negedge clk);
        start = 1'b1;
        s_valid = 1'b1; s_bits = 12'h008;
        @(negedge clk);
        start = 1'b0; s_valid = 1'b0; s_bits = '0;
        model_acc = '0;
        repeat (15) @(negedge clk);
        chk(o_valid == 1'b0, "R9 abort", o_valid, 0);
        beat(1'b1, 12'h020, 1'b1);
        wait_valid(1'b1, "R9 latency after abort");
        chk(o_idx == 28'hFFFFFF5 && o_len == 4'd1, "R9 cleared map", o_idx, 28'hFFFFFF5);
        do_ack();

        // random sequences
        for (int s = 0; s < 40; s++) begin
            int nb;
            if (($urandom % 4) != 0) do_start();
            nb = int'($urandom % 4);
            for (int b = 0; b < nb; b++) begin
                logic [11:0] bits;
                bits = (s % 2 == 0) ? 12'($urandom) : 12'($urandom & $urandom);
                beat(($urandom % 5) != 0, bits, 1'b0);
            end
            beat(1'b1, 12'($urandom & $urandom & $urandom), 1'b1);
            wait_valid(1'b1, "R3 random latency");
            check_result("R2 random");
            repeat (int'($urandom % 3)) @(negedge clk);
            do_ack();
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule